// File: doc/BRIEF.md
# Four-Function Arithmetic Logic Unit with Overflow Flags

This block is a purely combinational arithmetic logic unit of parameterised width. Two operands and a two-bit operation code go in; a result and three status flags come out in the same cycle, with no clock and no reset. Addition and subtraction share one ripple-carry chain of one-bit full-adder cells. For subtraction, every bit of the second operand is inverted by an XOR stage, and a 1 goes into the bottom carry, so the chain adds the two's complement. Bitwise AND and OR are formed alongside the chain, and a one-hot selector passes one of the three candidate values to the result.

A small decoder turns the operation code into a struct of strobes. The strobes are the subtract control, the result-source picks and a flag enable. The datapath consumes that struct. The flags report the carry leaving the top cell and an unsigned overflow whose meaning depends on direction: carry set on add, carry clear on subtract. They also report a signed overflow, formed as the XOR of the carries entering and leaving the top cell. For the logical operations all three flags are held at 0.

Top module: `alu_core`

## Requirements
- R1: Operation code 2'b00 gives `result` = `opA` + `opB` modulo 2^DATA_W.
- R2: Operation code 2'b01 gives `result` = `opA` − `opB` modulo 2^DATA_W.
- R3: Operation code 2'b10 gives `result` = `opA` AND `opB`, bit by bit.
- R4: Operation code 2'b11 gives `result` = `opA` OR `opB`, bit by bit.
- R5: For codes 2'b00 and 2'b01, `carryOut` is the carry leaving the most significant cell. For 2'b00 this is bit DATA_W of `opA`+`opB`. For 2'b01 it is bit DATA_W of `opA` + ~`opB` + 1. For 2'b10 and 2'b11, `carryOut` is 0.
- R6: For code 2'b00, `ovfUnsigned` is 1 exactly when the true sum exceeds 2^DATA_W − 1.
- R7: For code 2'b01, `ovfUnsigned` is 1 exactly when `opA` < `opB` as unsigned numbers, which is when the top carry is 0.
- R8: For codes 2'b00 and 2'b01, `ovfSigned` is 1 exactly when the two's-complement result falls outside the signed range of DATA_W bits. At DATA_W=4 this includes 0111+0001 and 1000+1111.
- R9: For codes 2'b10 and 2'b11, `ovfUnsigned` and `ovfSigned` read 0 whatever the operands are.
- R10: Subtracting equal operands gives a zero result with `carryOut` = 1, `ovfUnsigned` = 0 and `ovfSigned` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand (subtrahend for 2'b01) |
| opSel | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | DATA_W | Selected result |
| carryOut | output | 1 | Carry out of the top adder cell (0 for logical codes) |
| ovfUnsigned | output | 1 | Unsigned overflow, direction-aware (0 for logical codes) |
| ovfSigned | output | 1 | Signed overflow (0 for logical codes) |

## Verification
Signed and unsigned overflow can be raised together by one operation. Two examples are 1000+1111 and 0111−1000 at four bits, where the top carry and the carry into the top cell differ while the unsigned bound is also crossed. The bench sweeps every operand pair at DATA_W=4 under all four codes, which provokes both flags together as well as each flag alone. It judges each flag separately against values computed from integer sums and signed ranges.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } aluOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic subtract;     // invert B and inject carry-in of 1
    logic pickSum;      // route adder output to result
    logic pickAnd;      // route AND plane to result
    logic pickOr;       // route OR plane to result
    logic flagsEnable;  // arithmetic op: flags are meaningful
  } aluStrobes_t;

endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
  input  logic bitA,
  input  logic bitB,
  input  logic carryIn,
  output logic sumBit,
  output logic carryNext
);

  logic halfSum;

  always_comb begin
    halfSum   = bitA ^ bitB;
    sumBit    = halfSum ^ carryIn;
    carryNext = (bitA & bitB) | (halfSum & carryIn);
  end

endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0]  opSel,
  output aluStrobes_t strobes
);

  aluOp_e opCode;

  always_comb begin
    opCode  = aluOp_e'(opSel);
    strobes = '0;
    unique case (opCode)
      OP_ADD: begin
        strobes.pickSum     = 1'b1;
        strobes.flagsEnable = 1'b1;
      end
      OP_SUB: begin
        strobes.subtract    = 1'b1;
        strobes.pickSum     = 1'b1;
        strobes.flagsEnable = 1'b1;
      end
      OP_AND:  strobes.pickAnd = 1'b1;
      OP_OR:   strobes.pickOr  = 1'b1;
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              ovfUnsigned,
  output logic              ovfSigned
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bPrepared;
  logic [DATA_W-1:0] sumWord;
  logic [DATA_W-1:0] andWord;
  logic [DATA_W-1:0] orWord;
  logic [DATA_W:0]   carryChain;

  // Conditional inversion of B for subtraction
  assign bPrepared     = opB ^ {DATA_W{strobes.subtract}};
  assign carryChain[0] = strobes.subtract;

  // Ripple chain of full-adder cells
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_ripple
    alu_fa_cell u_cell (
      .bitA      (opA[gi]),
      .bitB      (bPrepared[gi]),
      .carryIn   (carryChain[gi]),
      .sumBit    (sumWord[gi]),
      .carryNext (carryChain[gi+1])
    );
  end

  // Logic planes, built alongside the adder
  assign andWord = opA & opB;
  assign orWord  = opA | opB;

  // One-hot AND-OR result selector
  always_comb begin
    result = ({DATA_W{strobes.pickSum}} & sumWord)
           | ({DATA_W{strobes.pickAnd}} & andWord)
           | ({DATA_W{strobes.pickOr}}  & orWord);
  end

  // Status flags, forced low for logical operations
  always_comb begin
    carryOut    = strobes.flagsEnable & carryChain[DATA_W];
    ovfUnsigned = strobes.flagsEnable & (carryChain[DATA_W] ^ strobes.subtract);
    ovfSigned   = strobes.flagsEnable & (carryChain[DATA_W] ^ carryChain[MSB]);
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        opSel,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              ovfUnsigned,
  output logic              ovfSigned
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .opA         (opA),
    .opB         (opB),
    .strobes     (strobes),
    .result      (result),
    .carryOut    (carryOut),
    .ovfUnsigned (ovfUnsigned),
    .ovfSigned   (ovfSigned)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [1:0]        opSel,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              ovfUnsigned,
  input logic              ovfSigned
);

  localparam int MSB = DATA_W - 1;

  logic signA, signB, signR, isArith;

  always_comb begin
    signA   = opA[MSB];
    signB   = opB[MSB];
    signR   = result[MSB];
    isArith = ~opSel[1];

    // R3: AND plane
    if (opSel == 2'b10) assert_and_plane_R3: assert (result == (opA & opB));
    // R4: OR plane
    if (opSel == 2'b11) assert_or_plane_R4: assert (result == (opA | opB));
    // R9: logical ops carry no flags (R5 for carryOut)
    if (!isArith) assert_quiet_flags_R9: assert (!carryOut && !ovfUnsigned && !ovfSigned);
    // R6: unsigned add overflow follows the carry
    if (opSel == 2'b00) assert_add_unsigned_R6: assert (ovfUnsigned == carryOut);
    // R7: unsigned subtract overflow is a missing carry
    if (opSel == 2'b01) assert_sub_borrow_R7: assert (ovfUnsigned == !carryOut);
    // R8: signed add overflow from sign bits
    if (opSel == 2'b00)
      assert_add_signed_R8: assert (ovfSigned == ((signA == signB) && (signR != signA)));
    // R8: signed subtract overflow from sign bits
    if (opSel == 2'b01)
      assert_sub_signed_R8: assert (ovfSigned == ((signA != signB) && (signR != signA)));
    // R10: equal operands subtract cleanly
    if (opSel == 2'b01 && opA == opB)
      assert_equal_sub_R10: assert (result == '0 && carryOut && !ovfUnsigned && !ovfSigned);
  end

endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .opA         (opA),
  .opB         (opB),
  .opSel       (opSel),
  .result      (result),
  .carryOut    (carryOut),
  .ovfUnsigned (ovfUnsigned),
  .ovfSigned   (ovfSigned)
);

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;

  localparam int NW = 4;
  localparam int WW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NW-1:0] opA, opB, result;
  logic [1:0]    opSel;
  logic          carryOut, ovfUnsigned, ovfSigned;

  logic [WW-1:0] wA, wB, wResult;
  logic [1:0]    wSel;
  logic          wCarry, wOvfU, wOvfS;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_core #(.DATA_W(NW)) u_dut (
    .opA(opA), .opB(opB), .opSel(opSel), .result(result),
    .carryOut(carryOut), .ovfUnsigned(ovfUnsigned), .ovfSigned(ovfSigned)
  );

  alu_core #(.DATA_W(WW)) u_wide (
    .opA(wA), .opB(wB), .opSel(wSel), .result(wResult),
    .carryOut(wCarry), .ovfUnsigned(wOvfU), .ovfSigned(wOvfS)
  );

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: sel=%0d a=%0d b=%0d got=%0d expected=%0d",
               req, opSel, opA, opB, got, exp);
    end
  endtask

  task automatic checkWide(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: wide sel=%0d a=%h b=%h got=%0d expected=%0d",
               req, wSel, wA, wB, got, exp);
    end
  endtask

  function automatic int toSigned(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  initial begin
    opA = '0; opB = '0; opSel = 2'b00;
    wA = '0; wB = '0; wSel = 2'b00;
    @(negedge clk);
    // Idle state: 0 + 0
    check("R1 idle result", result, 0);
    check("R5 idle carry", carryOut, 0);

    for (int sel = 0; sel < 4; sel++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int raw, expR, expC, expU, expS, sv;
          @(posedge clk);
          opSel = 2'(sel); opA = 4'(a); opB = 4'(b);
          @(negedge clk);
          case (sel)
            0: begin
              raw = a + b;
              expR = raw % 16; expC = raw / 16; expU = (raw > 15) ? 1 : 0;
              sv = toSigned(a) + toSigned(b);
              expS = (sv > 7 || sv < -8) ? 1 : 0;
              check("R1 sum", result, expR);
              check("R5 add carry", carryOut, expC);
              check("R6 add unsigned ovf", ovfUnsigned, expU);
              check("R8 add signed ovf", ovfSigned, expS);
            end
            1: begin
              raw = a + (15 - b) + 1;
              expR = raw % 16; expC = raw / 16; expU = (a < b) ? 1 : 0;
              sv = toSigned(a) - toSigned(b);
              expS = (sv > 7 || sv < -8) ? 1 : 0;
              check("R2 difference", result, expR);
              check("R5 sub carry", carryOut, expC);
              check("R7 sub unsigned ovf", ovfUnsigned, expU);
              check("R8 sub signed ovf", ovfSigned, expS);
              if (a == b) begin
                check("R10 equal sub result", result, 0);
                check("R10 equal sub carry", carryOut, 1);
                check("R10 equal sub flags", {ovfUnsigned, ovfSigned}, 0);
              end
            end
            2: begin
              check("R3 and", result, a & b);
              check("R5 and carry", carryOut, 0);
              check("R9 and flags", {ovfUnsigned, ovfSigned}, 0);
            end
            default: begin
              check("R4 or", result, a | b);
              check("R5 or carry", carryOut, 0);
              check("R9 or flags", {ovfUnsigned, ovfSigned}, 0);
            end
          endcase
        end
      end
    end

    // Named signed-overflow examples at four bits (R8)
    @(posedge clk); opSel = 2'b00; opA = 4'b0111; opB = 4'b0001;
    @(negedge clk); check("R8 0111+0001", ovfSigned, 1);
    @(posedge clk); opA = 4'b1000; opB = 4'b1111;
    @(negedge clk); check("R8 1000+1111", ovfSigned, 1);

    // Default-width spot checks
    @(posedge clk); wSel = 2'b00; wA = 32'hFFFF_FFFF; wB = 32'h1;
    @(negedge clk);
    checkWide("R1 wide wrap", wResult, 0);
    checkWide("R6 wide unsigned ovf", wOvfU, 1);
    checkWide("R8 wide no signed ovf", wOvfS, 0);
    @(posedge clk); wA = 32'h7FFF_FFFF; wB = 32'h1;
    @(negedge clk);
    checkWide("R8 wide signed ovf", wOvfS, 1);
    checkWide("R6 wide no unsigned ovf", wOvfU, 0);
    @(posedge clk); wSel = 2'b01; wA = 32'hDEAD_BEEF; wB = 32'hDEAD_BEEF;
    @(negedge clk);
    checkWide("R10 wide equal result", wResult, 0);
    checkWide("R10 wide equal carry", wCarry, 1);
    checkWide("R10 wide equal flags", {wOvfU, wOvfS}, 0);
    @(posedge clk); wA = 32'h1; wB = 32'h2;
    @(negedge clk);
    checkWide("R2 wide borrow result", wResult, 64'hFFFF_FFFF);
    checkWide("R7 wide borrow", wOvfU, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100_000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, got=hang expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule